// File: doc/BRIEF.md
# Tick-Driven Calendar Counter with Deferred Writes

This block keeps wall-clock time and a calendar date in two packed binary words. The time word holds hours, minutes and seconds. The date word holds day, month, a six-bit year offset counted from a base year (1970 by default), and a stored leap-year flag. Each single-cycle pulse on the one-second tick input advances the time by one second. A carry out of 23:59:59 advances the date. The date logic handles month lengths, February in leap years and the roll into a new year.

Software writes to the time word or the date word do not land at once. A write loads a pending copy and raises a busy flag for that word. The flag shows on the busy outputs and in the control word. The pending copy replaces the live word on the next tick and takes the place of that tick's increment. The busy flag drops on the same edge, so software can poll it to learn when the write has taken effect. A third busy position is kept for alarm-field writes. It always reads zero here.

Top module: `calendar_counter`

## Requirements
- R1: After reset the control word (address 0) reads 0, the time word (address 1) reads 0 and the date word (address 2) reads 0x00000101, which is day 1, month 1, offset 0, leap 0. Address 3 reads 0.
- R2: Each tick adds one second to the time word, with seconds in bits [5:0], minutes in [13:8] and hours in [20:16]. Without a tick, neither the time word nor the date word changes.
- R3: Seconds carry into minutes at 60, minutes carry into hours at 60, and hours wrap at 24. The wrap at 24 advances the date by one day.
- R4: In the date word, day sits in bits [4:0] and month (1–12) in bits [11:8]. The day wraps to 1 after day 31 of months 1, 3, 5, 7, 8, 10 and 12, after day 30 of months 4, 6, 9 and 11, and after day 28 of February, or day 29 when the leap flag (bit 22) is set.
- R5: When the month wraps from 12 to 1, the year offset in bits [21:16] increments. The leap flag is then recomputed as 1 exactly when offset plus 1970 is divisible by 4.
- R6: The year offset 63 (year 2033) wraps to offset 0 on year rollover, with the leap flag cleared.
- R7: A write to address 1 sets the time busy flag. This is busyFlags[1] and control bit 8, and it is visible after the edge that samples the write. The flag stays set until the commit. The readable time word does not change before the commit. The last write before the commit wins.
- R8: A pending time write is loaded on the next tick in place of that tick's increment, and the time busy flag clears on the same edge.
- R9: A write to address 2 sets the date busy flag. This is busyFlags[0] and control bit 7. The pending date is loaded on the next tick in place of any day carry, and the flag clears on that same edge.
- R10: Writes to address 0 have no effect. The alarm busy position (busyFlags[2], control bit 9) and every other control bit read 0.
- R11: Bits outside the time fields are dropped on a time write. The date write keeps day, month, year offset and the leap flag exactly as written.
- R12: A write sampled on the same edge as a tick is not committed by that tick. It waits for the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 control, 1 time, 2 date |
| wrData | input | 32 | Write data |
| rdAddr | input | 2 | Read address, same map as wrAddr |
| rdData | output | 32 | Read data, combinational from rdAddr |
| busyFlags | output | 3 | {alarm, time, date} write-busy flags |

## Verification
A write sampled on a clock edge raises its busy flag straight after that edge. A tick sampled on an edge changes the time and date words, and clears any busy flag, after that same edge. Read data follows rdAddr with no register in the path. For these reasons the bench drives its inputs 1 ns after the rising edge. It checks explicit literal values shortly after that, and it compares against its behavioural model at every falling edge. At each of those points, all effects of the edge just taken are already visible, and none of the next edge's effects are.

// File: rtl/calendar_pkg.sv
package calendar_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  localparam int SEC_W = 6;
  localparam int MIN_W = 6;
  localparam int HOUR_W = 5;
  localparam int DAY_W = 5;
  localparam int MON_W = 4;
  localparam int YEAR_W = 6;
  localparam int BUSY_DATE_POS = 7;
  localparam int BUSY_TIME_POS = 8;
  localparam int BUSY_ALARM_POS = 9;

  localparam logic [SEC_W-1:0]  SEC_LAST  = SEC_W'(59);
  localparam logic [MIN_W-1:0]  MIN_LAST  = MIN_W'(59);
  localparam logic [HOUR_W-1:0] HOUR_LAST = HOUR_W'(23);
  localparam logic [MON_W-1:0]  MON_LAST  = MON_W'(12);

  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_TIME = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_DATE = ADDR_W'(2);

  typedef struct packed {
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } clockTimeT;

  typedef struct packed {
    logic              leap;
    logic [YEAR_W-1:0] year;
    logic [MON_W-1:0]  month;
    logic [DAY_W-1:0]  day;
  } calDateT;

  typedef struct packed {
    logic advance;
    logic commitTime;
    logic commitDate;
  } calStrobeT;

  function automatic clockTimeT unpackTime(input logic [DATA_W-1:0] w);
    clockTimeT t;
    t.sec  = w[SEC_W-1:0];
    t.min  = w[8 +: MIN_W];
    t.hour = w[16 +: HOUR_W];
    return t;
  endfunction

  function automatic logic [DATA_W-1:0] packTime(input clockTimeT t);
    logic [DATA_W-1:0] w;
    w = '0;
    w[SEC_W-1:0]   = t.sec;
    w[8 +: MIN_W]  = t.min;
    w[16 +: HOUR_W] = t.hour;
    return w;
  endfunction

  function automatic calDateT unpackDate(input logic [DATA_W-1:0] w);
    calDateT d;
    d.day   = w[DAY_W-1:0];
    d.month = w[8 +: MON_W];
    d.year  = w[16 +: YEAR_W];
    d.leap  = w[22];
    return d;
  endfunction

  function automatic logic [DATA_W-1:0] packDate(input calDateT d);
    logic [DATA_W-1:0] w;
    w = '0;
    w[DAY_W-1:0]    = d.day;
    w[8 +: MON_W]   = d.month;
    w[16 +: YEAR_W] = d.year;
    w[22]           = d.leap;
    return w;
  endfunction

  function automatic logic [DAY_W-1:0] lastDay(input logic [MON_W-1:0] m, input logic leap);
    case (m)
      MON_W'(2):  return leap ? DAY_W'(29) : DAY_W'(28);
      MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): return DAY_W'(30);
      default:    return DAY_W'(31);
    endcase
  endfunction
endpackage

// File: rtl/calendar_ctrl.sv
module calendar_ctrl
  import calendar_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output calStrobeT         strobe,
  output clockTimeT         pendTime,
  output calDateT           pendDate,
  output logic              timeBusy,
  output logic              dateBusy
);
  logic wrTime;
  logic wrDate;

  assign wrTime = wrEn && (wrAddr == ADDR_TIME);
  assign wrDate = wrEn && (wrAddr == ADDR_DATE);

  // A commit happens only on a tick while a write is already pending.
  always_comb begin
    strobe.advance    = tick;
    strobe.commitTime = tick && timeBusy;
    strobe.commitDate = tick && dateBusy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendTime <= '0;
      pendDate <= '0;
      timeBusy <= 1'b0;
      dateBusy <= 1'b0;
    end else begin
      if (wrTime) begin
        pendTime <= unpackTime(wrData);
        timeBusy <= 1'b1;
      end else if (strobe.commitTime) begin
        timeBusy <= 1'b0;
      end
      if (wrDate) begin
        pendDate <= unpackDate(wrData);
        dateBusy <= 1'b1;
      end else if (strobe.commitDate) begin
        dateBusy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/calendar_datapath.sv
module calendar_datapath
  import calendar_pkg::*;
#(
  parameter int BASE_YEAR = 1970
) (
  input  logic      clk,
  input  logic      rstN,
  input  calStrobeT strobe,
  input  clockTimeT pendTime,
  input  calDateT   pendDate,
  output clockTimeT curTime,
  output calDateT   curDate
);
  localparam int SUM_W = 12;

  clockTimeT nextTime;
  calDateT   nextDate;
  logic      dayCarry;
  logic [YEAR_W-1:0] yearInc;

  function automatic logic leapOf(input logic [YEAR_W-1:0] off);
    logic [SUM_W-1:0] full;
    full = SUM_W'(off) + SUM_W'(BASE_YEAR);
    return (full[1:0] == 2'b00);
  endfunction

  always_comb begin
    nextTime = curTime;
    dayCarry = 1'b0;
    if (strobe.commitTime) begin
      nextTime = pendTime;
    end else if (strobe.advance) begin
      if (curTime.sec >= SEC_LAST) begin
        nextTime.sec = '0;
        if (curTime.min >= MIN_LAST) begin
          nextTime.min = '0;
          if (curTime.hour >= HOUR_LAST) begin
            nextTime.hour = '0;
            dayCarry = 1'b1;
          end else begin
            nextTime.hour = curTime.hour + 1'b1;
          end
        end else begin
          nextTime.min = curTime.min + 1'b1;
        end
      end else begin
        nextTime.sec = curTime.sec + 1'b1;
      end
    end
  end

  assign yearInc = curDate.year + 1'b1;

  always_comb begin
    nextDate = curDate;
    if (strobe.commitDate) begin
      nextDate = pendDate;
    end else if (dayCarry) begin
      if (curDate.day >= lastDay(curDate.month, curDate.leap)) begin
        nextDate.day = DAY_W'(1);
        if (curDate.month >= MON_LAST) begin
          nextDate.month = MON_W'(1);
          nextDate.year  = yearInc;
          nextDate.leap  = leapOf(yearInc);
        end else begin
          nextDate.month = curDate.month + 1'b1;
        end
      end else begin
        nextDate.day = curDate.day + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curTime <= '0;
      curDate <= '{leap: 1'b0, year: '0, month: MON_W'(1), day: DAY_W'(1)};
    end else begin
      curTime <= nextTime;
      curDate <= nextDate;
    end
  end
endmodule

// File: rtl/calendar_counter.sv
module calendar_counter
  import calendar_pkg::*;
#(
  parameter int BASE_YEAR = 1970
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [2:0]        busyFlags
);
  calStrobeT strobe;
  clockTimeT pendTime;
  calDateT   pendDate;
  clockTimeT timeQ;
  calDateT   dateQ;
  logic      timeBusy;
  logic      dateBusy;
  logic [DATA_W-1:0] ctrlWord;

  calendar_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .strobe   (strobe),
    .pendTime (pendTime),
    .pendDate (pendDate),
    .timeBusy (timeBusy),
    .dateBusy (dateBusy)
  );

  calendar_datapath #(.BASE_YEAR(BASE_YEAR)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pendTime (pendTime),
    .pendDate (pendDate),
    .curTime  (timeQ),
    .curDate  (dateQ)
  );

  always_comb begin
    ctrlWord = '0;
    ctrlWord[BUSY_DATE_POS]  = dateBusy;
    ctrlWord[BUSY_TIME_POS]  = timeBusy;
    ctrlWord[BUSY_ALARM_POS] = 1'b0;
  end

  assign busyFlags = {1'b0, timeBusy, dateBusy};

  always_comb begin
    case (rdAddr)
      ADDR_CTRL: rdData = ctrlWord;
      ADDR_TIME: rdData = packTime(timeQ);
      ADDR_DATE: rdData = packDate(dateQ);
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/calendar_checker.sv
module calendar_checker
  import calendar_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [2:0]        busyFlags,
  input clockTimeT         timeQ,
  input calDateT           dateQ
);
  logic wrTimeC;
  logic wrDateC;
  assign wrTimeC = wrEn && (wrAddr == ADDR_TIME);
  assign wrDateC = wrEn && (wrAddr == ADDR_DATE);

  p_wr_time_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrTimeC |=> busyFlags[1]);

  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    busyFlags[1] && !tick |=> busyFlags[1]);

  p_commit_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    busyFlags[1] && tick && !wrTimeC |=> !busyFlags[1]);

  p_wr_date_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrDateC |=> busyFlags[0]);

  p_no_tick_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(timeQ) && $stable(dateQ));

  p_sec_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    tick && !busyFlags[1] && (timeQ.sec < SEC_LAST)
    |=> timeQ.sec == SEC_W'($past(timeQ.sec) + SEC_W'(1)));

  p_same_edge_date_r12: assert property (@(posedge clk) disable iff (!rstN)
    wrDateC && tick && !busyFlags[0] && (timeQ.sec != SEC_LAST) |=> $stable(dateQ));
endmodule

bind calendar_counter calendar_checker u_calChk (
  .clk       (clk),
  .rstN      (rstN),
  .tick      (tick),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .busyFlags (busyFlags),
  .timeQ     (timeQ),
  .dateQ     (dateQ)
);

// File: tb/test_calendar_counter.sv
`timescale 1ns/1ps
module test_calendar_counter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [31:0] wrData = 32'd0;
  logic [1:0]  rdAddr = 2'd0;
  logic [31:0] rdData;
  logic [2:0]  busyFlags;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string curReq = "R1";

  calendar_counter i_calendar_counter (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .busyFlags(busyFlags)
  );

  always #2.5 clk = ~clk;

  // Behavioural reference model
  int mSec, mMin, mHr, mDay, mMon, mYr, mLeap;
  logic [31:0] pT, pD;
  bit bT, bD, carry;

  function automatic int daysIn(int m, int lp);
    if (m == 2) return lp ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] timeWord();
    return (mHr << 16) | (mMin << 8) | mSec;
  endfunction

  function automatic logic [31:0] dateWord();
    return (mLeap << 22) | (mYr << 16) | (mMon << 8) | mDay;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSec = 0; mMin = 0; mHr = 0; mDay = 1; mMon = 1; mYr = 0; mLeap = 0;
      bT = 0; bD = 0; pT = 0; pD = 0;
    end else begin
      if (tick) begin
        carry = 0;
        if (bT) begin
          mSec = pT[5:0]; mMin = pT[13:8]; mHr = pT[20:16];
        end else begin
          mSec++;
          if (mSec == 60) begin
            mSec = 0; mMin++;
            if (mMin == 60) begin
              mMin = 0; mHr++;
              if (mHr == 24) begin mHr = 0; carry = 1; end
            end
          end
        end
        if (bD) begin
          mDay = pD[4:0]; mMon = pD[11:8]; mYr = pD[21:16]; mLeap = pD[22];
        end else if (carry) begin
          mDay++;
          if (mDay > daysIn(mMon, mLeap)) begin
            mDay = 1; mMon++;
            if (mMon == 13) begin
              mMon = 1; mYr = (mYr + 1) % 64;
              mLeap = ((mYr + 1970) % 4 == 0) ? 1 : 0;
            end
          end
        end
        bT = 0; bD = 0;
      end
      if (wrEn && wrAddr == 2'd1) begin pT = wrData; bT = 1; end
      if (wrEn && wrAddr == 2'd2) begin pD = wrData; bD = 1; end
    end
  end

  // Per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    logic [31:0] exp;
    if (rstN && !finished) begin
      case (rdAddr)
        2'd0: exp = (32'(bT) << 8) | (32'(bD) << 7);
        2'd1: exp = timeWord();
        2'd2: exp = dateWord();
        default: exp = 32'd0;
      endcase
      checks++;
      if (rdData !== exp) begin
        fails++;
        $display("FAIL %s model rdData addr=%0d actual=%h expected=%h", curReq, rdAddr, rdData, exp);
      end
      checks++;
      if (busyFlags !== {1'b0, bT, bD}) begin
        fails++;
        $display("FAIL %s model busyFlags actual=%b expected=%b", curReq, busyFlags, {1'b0, bT, bD});
      end
    end
  end

  task automatic peek(input logic [1:0] a, input logic [31:0] exp, input string req);
    rdAddr = a;
    #0.2;
    checks++;
    if (rdData !== exp) begin
      fails++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, rdData, exp);
    end
  endtask

  task automatic chkBusy(input logic [2:0] exp, input string req);
    checks++;
    if (busyFlags !== exp) begin
      fails++;
      $display("FAIL %s busyFlags actual=%b expected=%b", req, busyFlags, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  task automatic tickOnce();
    tick = 1'b1;
    step();
    tick = 1'b0;
  endtask

  task automatic rollDay(input logic [31:0] d);
    wr(2'd1, 32'h00173B3B);
    wr(2'd2, d);
    tickOnce();
    tickOnce();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R1 reset state
    curReq = "R1";
    peek(2'd0, 32'h0, "R1");
    peek(2'd1, 32'h0, "R1");
    peek(2'd2, 32'h00000101, "R1");
    peek(2'd3, 32'h0, "R1");
    chkBusy(3'b000, "R1");
    // R2 plain ticking, idle cycles hold
    curReq = "R2";
    tickOnce(); step(); tickOnce(); tickOnce(); step(); step();
    peek(2'd1, 32'h00000003, "R2");
    // R7 busy visible, time unchanged, latest write wins
    curReq = "R7";
    wr(2'd1, 32'h00000A3B);
    chkBusy(3'b010, "R7");
    peek(2'd0, 32'h00000100, "R7");
    peek(2'd1, 32'h00000003, "R7");
    step(); step();
    chkBusy(3'b010, "R7");
    wr(2'd1, 32'h00003B3B);
    // R8 commit overrides increment
    curReq = "R8";
    tickOnce();
    peek(2'd1, 32'h00003B3B, "R8");
    chkBusy(3'b000, "R8");
    // R3 carries
    curReq = "R3";
    tickOnce();
    peek(2'd1, 32'h00010000, "R3");
    wr(2'd1, 32'h00000A3B); tickOnce(); tickOnce();
    peek(2'd1, 32'h00000B00, "R3");
    // R9 date busy with day carry from 23:59:59
    curReq = "R9";
    wr(2'd1, 32'h00173B3B);
    wr(2'd2, 32'h0000010F);
    peek(2'd0, 32'h00000180, "R9");
    tickOnce();
    peek(2'd0, 32'h0, "R9");
    peek(2'd2, 32'h0000010F, "R9");
    curReq = "R3";
    tickOnce();
    peek(2'd1, 32'h0, "R3");
    peek(2'd2, 32'h00000110, "R3");
    // R4 month lengths
    curReq = "R4";
    rollDay(32'h0000011F); peek(2'd2, 32'h00000201, "R4");
    rollDay(32'h0000011E); peek(2'd2, 32'h0000011F, "R4");
    rollDay(32'h0000041E); peek(2'd2, 32'h00000501, "R4");
    rollDay(32'h0000021C); peek(2'd2, 32'h00000301, "R4");
    rollDay(32'h0040021C); peek(2'd2, 32'h0040021D, "R4");
    rollDay(32'h0040021D); peek(2'd2, 32'h00400301, "R4");
    // R5 year rollover and leap recompute
    curReq = "R5";
    rollDay(32'h00010C1F); peek(2'd2, 32'h00420101, "R5");
    rollDay(32'h00420C1F); peek(2'd2, 32'h00030101, "R5");
    // R6 offset wrap
    curReq = "R6";
    rollDay(32'h003F0C1F); peek(2'd2, 32'h00000101, "R6");
    peek(2'd1, 32'h0, "R6");
    // R10 control writes ignored
    curReq = "R10";
    wr(2'd0, 32'hFFFFFFFF);
    peek(2'd0, 32'h0, "R10");
    chkBusy(3'b000, "R10");
    peek(2'd1, 32'h0, "R10");
    peek(2'd2, 32'h00000101, "R10");
    // R11 unused time bits dropped
    curReq = "R11";
    wr(2'd1, 32'hFFC0C0C5);
    tickOnce();
    peek(2'd1, 32'h00000005, "R11");
    // R12 write on the tick edge waits for the next tick
    curReq = "R12";
    tick = 1'b1; wrEn = 1'b1; wrAddr = 2'd2; wrData = 32'h00050306;
    step();
    tick = 1'b0; wrEn = 1'b0;
    peek(2'd2, 32'h00000101, "R12");
    peek(2'd0, 32'h00000080, "R12");
    peek(2'd1, 32'h00000006, "R12");
    tickOnce();
    peek(2'd2, 32'h00050306, "R12");
    peek(2'd1, 32'h00000007, "R12");
    chkBusy(3'b000, "R12");
    step(); step();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule